// File: doc/BRIEF.md
# Processor-to-Legacy Asynchronous Bus Cycle Controller

This controller sits between a processor whose bus announces each transfer with a single-clock start strobe and a legacy 16-bit bus that handshakes with an address strobe, two byte-lane data strobes and a returned data acknowledge. Each processor transfer is captured on its start strobe. The controller runs the matching legacy cycle and answers the processor with a one-clock transfer acknowledge. All signals are active high at this block's ports. Any pad inversion happens outside.

A 32-bit transfer is carried as two legacy word cycles, and the processor sees a single acknowledge at the end. An interrupt acknowledge steers the processor's interrupt level onto the legacy low address lines through its own address enable. If the legacy side answers it with the autovector input, the cycle ends without the data acknowledge. The transceiver output enables are produced here and gated by bus ownership, halt and the address strobe. A halt blocks the start of any new transfer but lets a running one finish.

Top module: `abus_bridge`

## Requirements
- R1: While reset is low, and in the first clock after it is released, every output is 0.
- R2: A start strobe seen while idle with halt low raises `leg_as` at the next clock edge.
- R3: Once the strobes are out, the legacy cycle stays open with `leg_as` high and no `cpu_ta` for as long as neither `leg_dtack` nor an autovector answer arrives.
- R4: For transfer type 11 (interrupt acknowledge) with `leg_avec` high, `cpu_ta` follows exactly three clocks after `leg_as` rose, and no data acknowledge is needed.
- R5: Each processor transfer yields exactly one `cpu_ta` pulse, one clock wide, in a clock where `leg_as` is low.
- R6: With size 00 (longword) and a transfer type other than 11, the controller runs two legacy cycles. The first has `leg_a1` = 0 (upper half) and the second has `leg_a1` = 1 (lower half). `cpu_ta` comes only after the second.
- R7: With size 01 (byte), `cpu_a0` = 0 drives only `leg_uds` and `cpu_a0` = 1 drives only `leg_lds`. Sizes 00, 10 and 11 drive both strobes.
- R8: Transfer type 11 raises `ae_iack` and puts the captured level on `leg_lvl`. Any other type raises `ae_norm` and holds `leg_lvl` at 0. The two enables are never high together.
- R9: An `oe_*` enable is high only while `cpu_own` is high, `cpu_halt` is low and `leg_as` is high. The read or write variant follows `cpu_rd`, and the 8-bit or 16-bit variant follows whether the size is byte.
- R10: While `cpu_halt` is high in idle, no legacy cycle starts. A pending start begins once halt falls, and halt raised during a cycle does not stop that cycle.
- R11: `leg_fc` reads 111 for type 11 and {`cpu_sup`, `cpu_inst`, not `cpu_inst`} for type 00. It reads 000 for types 01 and 10 and whenever `leg_as` is low.
- R12: On a read the data strobes rise together with `leg_as`. On a write they rise one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_ts | input | 1 | Processor transfer start, one clock |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_tt | input | 2 | Transfer type: 00 normal, 01/10 special, 11 interrupt acknowledge |
| cpu_siz | input | 2 | Size: 00 long, 01 byte, 10 word, 11 treated as word |
| cpu_a0 | input | 1 | Low address bit, selects byte lane |
| cpu_sup | input | 1 | Supervisor access |
| cpu_inst | input | 1 | Instruction fetch (0 = data) |
| cpu_lvl | input | LVL_W | Interrupt level from the processor address bits |
| cpu_own | input | 1 | Processor owns the legacy bus |
| cpu_halt | input | 1 | Halt request |
| leg_dtack | input | 1 | Legacy data acknowledge |
| leg_avec | input | 1 | Legacy autovector answer |
| cpu_ta | output | 1 | Transfer acknowledge to the processor |
| leg_as | output | 1 | Legacy address strobe |
| leg_uds | output | 1 | Upper (even) lane data strobe |
| leg_lds | output | 1 | Lower (odd) lane data strobe |
| leg_fc | output | 3 | Legacy function code |
| leg_a1 | output | 1 | Half select of a split longword |
| ae_norm | output | 1 | Enable for the normal address latch path |
| ae_iack | output | 1 | Enable for the interrupt-level address path |
| leg_lvl | output | LVL_W | Interrupt level steered onto the legacy low address lines |
| oe_rd16 | output | 1 | Read transceiver enable, 16-bit |
| oe_rd8 | output | 1 | Read transceiver enable, 8-bit |
| oe_wr16 | output | 1 | Write transceiver enable, 16-bit |
| oe_wr8 | output | 1 | Write transceiver enable, 8-bit |

## Verification
The hardest state to reach from the ports is a legacy cycle parked in its wait state while halt and loss of ownership are applied and then removed. The bench has to check that the transceiver enables drop and return while the address strobe and the wait are kept. The stimulus gets there with a responder model that can be told to withhold its acknowledge. That holds the cycle open for as long as the sequence needs, and the responder is released afterwards so the scoreboard still sees exactly one acknowledge. A pending start under halt is reached by raising halt before the start strobe and watching the address strobe stay low for several clocks.

// File: rtl/abus_pkg.sv
package abus_pkg;

   typedef enum logic [2:0] {
      ST_RESET = 3'd0,
      ST_IDLE  = 3'd1,
      ST_ADDR  = 3'd2,
      ST_STRB  = 3'd3,
      ST_WAIT  = 3'd4,
      ST_DONE  = 3'd5
   } bstate_e;

   localparam logic [1:0] TT_NORM = 2'b00;
   localparam logic [1:0] TT_IACK = 2'b11;

   localparam logic [1:0] SZ_LONG = 2'b00;
   localparam logic [1:0] SZ_BYTE = 2'b01;

   localparam logic [2:0] FC_IACK = 3'b111;
   localparam logic [2:0] FC_NONE = 3'b000;

   // attributes of one processor transfer, captured on its start strobe
   typedef struct packed {
      logic       rd;
      logic [1:0] tt;
      logic [1:0] siz;
      logic       sup;
      logic       inst;
      logic       a0;
   } xfer_t;

   function automatic logic [2:0] fc_of(input logic [1:0] tt, input logic sup,
                                        input logic inst);
      logic [2:0] code;
      if (tt == TT_IACK)      code = FC_IACK;
      else if (tt == TT_NORM) code = {sup, inst, ~inst};
      else                    code = FC_NONE;
      return code;
   endfunction

endpackage

// File: rtl/abus_seq.sv
module abus_seq
   import abus_pkg::*;
#(
   parameter int LVL_W      = 3,
   parameter bit SPLIT_LONG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ts_i,
   input  logic             halt_i,
   input  logic             dtack_i,
   input  logic             avec_i,
   input  logic             rd_i,
   input  logic [1:0]       tt_i,
   input  logic [1:0]       siz_i,
   input  logic             sup_i,
   input  logic             inst_i,
   input  logic             a0_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic             half_o,
   output logic             q_rd_o,
   output logic [1:0]       q_tt_o,
   output logic             q_sup_o,
   output logic             q_inst_o,
   output logic             q_byte_o,
   output logic             q_a0_o,
   output logic [LVL_W-1:0] q_lvl_o,
   output logic             as_ph_o,
   output logic             ds_ph_o,
   output logic             ta_o
);

   bstate_e          st, st_nx;
   xfer_t            req;
   logic [LVL_W-1:0] lvl_q;
   logic             pend;
   logic             half;
   logic             two_half;
   logic             last;
   logic             is_iack;
   logic             start;
   logic             ended;

   assign is_iack = (req.tt == TT_IACK);

   generate
      if (SPLIT_LONG) begin : g_split
         assign two_half = (req.siz == SZ_LONG) && !is_iack;
      end else begin : g_single
         assign two_half = 1'b0;
      end
   endgenerate

   assign last  = !two_half || half;
   assign start = (st == ST_IDLE) && (ts_i || pend) && !halt_i;
   assign ended = dtack_i || (is_iack && avec_i);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_RESET: st_nx = ST_IDLE;
         ST_IDLE:  if (start) st_nx = ST_ADDR;
         ST_ADDR:  st_nx = ST_STRB;
         ST_STRB:  st_nx = ST_WAIT;
         ST_WAIT:  if (ended) st_nx = ST_DONE;
         ST_DONE:  st_nx = last ? ST_IDLE : ST_ADDR;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_RESET;
         req   <= '0;
         lvl_q <= '0;
         pend  <= 1'b0;
         half  <= 1'b0;
      end else begin
         st <= st_nx;
         if (ts_i) begin
            req   <= '{rd: rd_i, tt: tt_i, siz: siz_i, sup: sup_i, inst: inst_i, a0: a0_i};
            lvl_q <= lvl_i;
         end
         if (start)     pend <= 1'b0;
         else if (ts_i) pend <= 1'b1;
         if (st == ST_DONE) half <= !last;
      end
   end

   assign as_ph_o  = (st == ST_ADDR) || (st == ST_STRB) || (st == ST_WAIT);
   assign ds_ph_o  = as_ph_o && (req.rd || (st != ST_ADDR));
   assign ta_o     = (st == ST_DONE) && last;
   assign half_o   = half;
   assign q_rd_o   = req.rd;
   assign q_tt_o   = req.tt;
   assign q_sup_o  = req.sup;
   assign q_inst_o = req.inst;
   assign q_byte_o = (req.siz == SZ_BYTE);
   assign q_a0_o   = req.a0;
   assign q_lvl_o  = lvl_q;

   // R2: an accepted start opens the address phase on the next edge
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && ts_i && !halt_i) |=> (st == ST_ADDR));
   // R3: no answer keeps the wait state
   a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !dtack_i && !(is_iack && avec_i)) |=> (st == ST_WAIT));
   // R4: autovector answer closes an interrupt acknowledge
   a_r4_autovec: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && is_iack && avec_i) |=> (st == ST_DONE));
   // R5: acknowledge to the processor is a single clock
   a_r5_ta_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ta_o |=> !ta_o);
   // R6: the first half of a longword chains straight into the second
   a_r6_second_half: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE && !last) |=> (st == ST_ADDR && half));
   // R10: halt keeps the controller idle
   a_r10_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && halt_i) |=> (st == ST_IDLE));

endmodule

// File: rtl/abus_lanes.sv
module abus_lanes
   import abus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       as_i,
   input  logic       ds_i,
   input  logic       byte_i,
   input  logic       a0_i,
   input  logic       half_i,
   input  logic       sup_i,
   input  logic       inst_i,
   input  logic [1:0] tt_i,
   output logic       uds_o,
   output logic       lds_o,
   output logic       a1_o,
   output logic [2:0] fc_o
);

   logic even_sel, odd_sel;

   // byte access picks one lane by the low address bit, other sizes use both
   assign even_sel = !byte_i || !a0_i;
   assign odd_sel  = !byte_i ||  a0_i;

   assign uds_o = ds_i && even_sel;
   assign lds_o = ds_i && odd_sel;
   assign a1_o  = as_i && half_i;
   assign fc_o  = as_i ? fc_of(tt_i, sup_i, inst_i) : FC_NONE;

   // R7: data strobes only inside an address strobe
   a_r7_strobe_in_as: assert property (@(posedge clk) disable iff (!rst_n)
      (uds_o || lds_o) |-> as_i);
   // R7: a byte never drives both lanes
   a_r7_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      byte_i |-> !(uds_o && lds_o));
   // R12: write strobes never lead the address strobe
   a_r12_ds_after_as: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uds_o || lds_o) |-> as_i);

endmodule

// File: rtl/abus_xcvr.sv
module abus_xcvr #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             as_i,
   input  logic             rd_i,
   input  logic             byte_i,
   input  logic             iack_i,
   input  logic             own_i,
   input  logic             halt_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic             ae_norm_o,
   output logic             ae_iack_o,
   output logic [LVL_W-1:0] lvl_o,
   output logic             oe_rd16_o,
   output logic             oe_rd8_o,
   output logic             oe_wr16_o,
   output logic             oe_wr8_o
);

   localparam int N_OE = 4;

   logic            gate;
   logic [N_OE-1:0] oe_vec;

   assign gate = own_i && !halt_i && as_i;

   // index bit 1 = read, bit 0 = byte
   generate
      for (genvar i = 0; i < N_OE; i++) begin : g_oe
         localparam bit IS_RD   = (i / 2) == 1;
         localparam bit IS_BYTE = (i % 2) == 1;
         assign oe_vec[i] = gate && (rd_i == IS_RD) && (byte_i == IS_BYTE);
      end
   endgenerate

   assign oe_wr16_o = oe_vec[0];
   assign oe_wr8_o  = oe_vec[1];
   assign oe_rd16_o = oe_vec[2];
   assign oe_rd8_o  = oe_vec[3];

   assign ae_norm_o = as_i && !iack_i;
   assign ae_iack_o = as_i &&  iack_i;
   assign lvl_o     = ae_iack_o ? lvl_i : '0;

   // R8: the two address paths are exclusive
   a_r8_ae_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ae_norm_o, ae_iack_o}));
   // R8: level lines quiet off the interrupt path
   a_r8_lvl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ae_iack_o |-> (lvl_o == '0));
   // R9: at most one transceiver direction and width at a time
   a_r9_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oe_vec));
   // R9: halt removes every transceiver enable
   a_r9_halt_kill: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |-> (oe_vec == '0));

endmodule

// File: rtl/abus_bridge.sv
module abus_bridge
   import abus_pkg::*;
#(
   parameter int LVL_W      = 3,
   parameter bit SPLIT_LONG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_ts,
   input  logic             cpu_rd,
   input  logic [1:0]       cpu_tt,
   input  logic [1:0]       cpu_siz,
   input  logic             cpu_a0,
   input  logic             cpu_sup,
   input  logic             cpu_inst,
   input  logic [LVL_W-1:0] cpu_lvl,
   input  logic             cpu_own,
   input  logic             cpu_halt,
   input  logic             leg_dtack,
   input  logic             leg_avec,
   output logic             cpu_ta,
   output logic             leg_as,
   output logic             leg_uds,
   output logic             leg_lds,
   output logic [2:0]       leg_fc,
   output logic             leg_a1,
   output logic             ae_norm,
   output logic             ae_iack,
   output logic [LVL_W-1:0] leg_lvl,
   output logic             oe_rd16,
   output logic             oe_rd8,
   output logic             oe_wr16,
   output logic             oe_wr8
);

   generate
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
         $error("abus_bridge: LVL_W must lie in 1..8");
      end
   endgenerate

   logic             half, q_rd, q_sup, q_inst, q_byte, q_a0;
   logic [1:0]       q_tt;
   logic [LVL_W-1:0] q_lvl;
   logic             as_ph, ds_ph;

   abus_seq #(.LVL_W(LVL_W), .SPLIT_LONG(SPLIT_LONG)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ts_i     (cpu_ts),
      .halt_i   (cpu_halt),
      .dtack_i  (leg_dtack),
      .avec_i   (leg_avec),
      .rd_i     (cpu_rd),
      .tt_i     (cpu_tt),
      .siz_i    (cpu_siz),
      .sup_i    (cpu_sup),
      .inst_i   (cpu_inst),
      .a0_i     (cpu_a0),
      .lvl_i    (cpu_lvl),
      .half_o   (half),
      .q_rd_o   (q_rd),
      .q_tt_o   (q_tt),
      .q_sup_o  (q_sup),
      .q_inst_o (q_inst),
      .q_byte_o (q_byte),
      .q_a0_o   (q_a0),
      .q_lvl_o  (q_lvl),
      .as_ph_o  (as_ph),
      .ds_ph_o  (ds_ph),
      .ta_o     (cpu_ta)
   );

   abus_lanes u_lanes (
      .clk    (clk),
      .rst_n  (rst_n),
      .as_i   (as_ph),
      .ds_i   (ds_ph),
      .byte_i (q_byte),
      .a0_i   (q_a0),
      .half_i (half),
      .sup_i  (q_sup),
      .inst_i (q_inst),
      .tt_i   (q_tt),
      .uds_o  (leg_uds),
      .lds_o  (leg_lds),
      .a1_o   (leg_a1),
      .fc_o   (leg_fc)
   );

   abus_xcvr #(.LVL_W(LVL_W)) u_xcvr (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_i      (as_ph),
      .rd_i      (q_rd),
      .byte_i    (q_byte),
      .iack_i    (q_tt == TT_IACK),
      .own_i     (cpu_own),
      .halt_i    (cpu_halt),
      .lvl_i     (q_lvl),
      .ae_norm_o (ae_norm),
      .ae_iack_o (ae_iack),
      .lvl_o     (leg_lvl),
      .oe_rd16_o (oe_rd16),
      .oe_rd8_o  (oe_rd8),
      .oe_wr16_o (oe_wr16),
      .oe_wr8_o  (oe_wr8)
   );

   assign leg_as = as_ph;

   // R5: the processor is answered only after the strobe has closed
   a_r5_ta_as_low: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ta |-> !leg_as);

endmodule

// File: tb/abus_bridge_test.sv
module abus_bridge_test;

   localparam int CLK_PERIOD = 10;
   localparam int LVL_W      = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cpu_ts, cpu_rd, cpu_a0, cpu_sup, cpu_inst, cpu_own, cpu_halt;
   logic [1:0]       cpu_tt, cpu_siz;
   logic [LVL_W-1:0] cpu_lvl;
   logic             leg_dtack, leg_avec;
   logic             cpu_ta, leg_as, leg_uds, leg_lds, leg_a1, ae_norm, ae_iack;
   logic [2:0]       leg_fc;
   logic [LVL_W-1:0] leg_lvl;
   logic             oe_rd16, oe_rd8, oe_wr16, oe_wr8;

   always #(CLK_PERIOD/2) clk = ~clk;

   abus_bridge #(.LVL_W(LVL_W)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_ts(cpu_ts), .cpu_rd(cpu_rd), .cpu_tt(cpu_tt),
      .cpu_siz(cpu_siz), .cpu_a0(cpu_a0), .cpu_sup(cpu_sup), .cpu_inst(cpu_inst),
      .cpu_lvl(cpu_lvl), .cpu_own(cpu_own), .cpu_halt(cpu_halt),
      .leg_dtack(leg_dtack), .leg_avec(leg_avec), .cpu_ta(cpu_ta), .leg_as(leg_as),
      .leg_uds(leg_uds), .leg_lds(leg_lds), .leg_fc(leg_fc), .leg_a1(leg_a1),
      .ae_norm(ae_norm), .ae_iack(ae_iack), .leg_lvl(leg_lvl), .oe_rd16(oe_rd16),
      .oe_rd8(oe_rd8), .oe_wr16(oe_wr16), .oe_wr8(oe_wr8)
   );

   typedef struct {
      logic             rd;
      logic [1:0]       tt;
      logic [1:0]       siz;
      logic             a0, sup, inst, avec;
      logic [LVL_W-1:0] lvl;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;
   bit   hold_ack = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, expv, $time);
      end
   endtask

   function automatic logic [2:0] e_fc(exp_t e);
      if (e.tt == 2'b11) return 3'b111;
      if (e.tt == 2'b00) return {e.sup, e.inst, ~e.inst};
      return 3'b000;
   endfunction
   function automatic logic [1:0] e_ds(exp_t e);   // {uds, lds}
      if (e.siz == 2'b01) return e.a0 ? 2'b01 : 2'b10;
      return 2'b11;
   endfunction
   function automatic int e_halves(exp_t e);
      return (e.siz == 2'b00 && e.tt != 2'b11) ? 2 : 1;
   endfunction
   function automatic logic [3:0] e_oe(exp_t e);   // {rd16, rd8, wr16, wr8}
      logic b;
      b = (e.siz == 2'b01);
      return {e.rd && !b, e.rd && b, !e.rd && !b, !e.rd && b};
   endfunction

   // legacy responder: random wait before acknowledge, silent on autovector
   int wcnt;
   always @(negedge clk) begin
      if (!rst_n || !leg_as) begin
         leg_dtack <= 1'b0;
         wcnt      <= -1;
      end else if (!leg_dtack && !hold_ack && !leg_avec) begin
         if (wcnt < 0)       wcnt <= int'($urandom_range(0, 3));
         else if (wcnt == 0) leg_dtack <= 1'b1;
         else                wcnt <= wcnt - 1;
      end
   end

   // monitor / scoreboard
   int         ncyc = 0, age = 0, since = 0;
   logic [1:0] a1s = 2'b00;
   logic       prev_as = 1'b0;
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if ({oe_rd16, oe_rd8, oe_wr16, oe_wr8} != 4'b0)
            chk(cpu_own && !cpu_halt && leg_as, "R9 oe gate", 1, 0);
         if (leg_as && !prev_as) begin
            ncyc++; a1s = {a1s[0], leg_a1}; age = 0; since = 0;
            if (exp_q.size() == 0) chk(1'b0, "R5 spurious cycle", 1, 0);
            else begin
               e = exp_q[0];
               chk(leg_fc == e_fc(e), "R11 fc", leg_fc, e_fc(e));
               chk({ae_iack, ae_norm} == ((e.tt == 2'b11) ? 2'b10 : 2'b01),
                   "R8 ae", {ae_iack, ae_norm}, (e.tt == 2'b11) ? 2 : 1);
               chk(leg_lvl == ((e.tt == 2'b11) ? e.lvl : '0), "R8 lvl", leg_lvl,
                   (e.tt == 2'b11) ? e.lvl : 0);
               chk({leg_uds, leg_lds} == (e.rd ? e_ds(e) : 2'b00), "R12 phase",
                   {leg_uds, leg_lds}, e.rd ? e_ds(e) : 0);
            end
         end else begin
            since++;
            if (leg_as && age == 0 && exp_q.size() != 0) begin
               age = 1;
               e = exp_q[0];
               chk({leg_uds, leg_lds} == e_ds(e), "R7 lanes", {leg_uds, leg_lds}, e_ds(e));
               if (cpu_own && !cpu_halt)
                  chk({oe_rd16, oe_rd8, oe_wr16, oe_wr8} == e_oe(e), "R9 oe variant",
                      {oe_rd16, oe_rd8, oe_wr16, oe_wr8}, e_oe(e));
            end
         end
         if (cpu_ta) begin
            chk(!leg_as, "R5 ta with as low", leg_as, 0);
            if (exp_q.size() == 0) chk(1'b0, "R5 extra ta", 1, 0);
            else begin
               e = exp_q.pop_front();
               chk(ncyc == e_halves(e), "R6 legacy cycles", ncyc, e_halves(e));
               if (e_halves(e) == 2) chk(a1s == 2'b01, "R6 half order", a1s, 1);
               if (e.tt == 2'b11 && e.avec) chk(since == 3, "R4 autovector timing", since, 3);
            end
            ncyc = 0;
         end
      end
      prev_as = leg_as;
   end

   task automatic start_acc(input logic rd, input logic [1:0] siz, input logic a0,
                            input logic [1:0] tt, input logic sup, input logic inst,
                            input logic [LVL_W-1:0] lvl, input logic avec);
      exp_t e;
      e = '{rd: rd, tt: tt, siz: siz, a0: a0, sup: sup, inst: inst, avec: avec, lvl: lvl};
      exp_q.push_back(e);
      cpu_rd = rd; cpu_siz = siz; cpu_a0 = a0; cpu_tt = tt;
      cpu_sup = sup; cpu_inst = inst; cpu_lvl = lvl; leg_avec = avec;
      cpu_ts = 1'b1;
      @(negedge clk);
      cpu_ts = 1'b0;
      if (!cpu_halt) chk(leg_as == 1'b1, "R2 strobe after start", leg_as, 1);
   endtask

   task automatic finish_acc();
      int nta = 0;
      for (int i = 0; i < 60; i++) begin
         if (cpu_ta) nta++;
         if (nta != 0 && !cpu_ta) break;
         @(negedge clk);
      end
      chk(nta == 1, "R5 one ta per transfer", nta, 1);
      leg_avec = 1'b0;
   endtask

   task automatic acc(input logic rd, input logic [1:0] siz, input logic a0,
                      input logic [1:0] tt, input logic sup, input logic inst,
                      input logic [LVL_W-1:0] lvl, input logic avec);
      start_acc(rd, siz, a0, tt, sup, inst, lvl, avec);
      finish_acc();
   endtask

   initial begin
      rst_n = 1'b0; cpu_ts = 0; cpu_rd = 0; cpu_a0 = 0; cpu_sup = 0; cpu_inst = 0;
      cpu_own = 1; cpu_halt = 0; cpu_tt = 0; cpu_siz = 0; cpu_lvl = 0; leg_avec = 0;
      repeat (3) @(negedge clk);
      // R1: idle outputs in reset
      chk({cpu_ta, leg_as, leg_uds, leg_lds, leg_a1, ae_norm, ae_iack, oe_rd16, oe_rd8,
           oe_wr16, oe_wr8} == '0 && leg_fc == 0 && leg_lvl == 0, "R1 reset outputs",
          {cpu_ta, leg_as, leg_uds, leg_lds}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({cpu_ta, leg_as, leg_uds, leg_lds, oe_rd16, oe_wr16} == '0, "R1 after release",
          {cpu_ta, leg_as, leg_uds, leg_lds}, 0);

      acc(1, 2'b10, 0, 2'b00, 1, 1, 0, 0);   // word read, R7 both lanes
      acc(0, 2'b01, 0, 2'b00, 0, 0, 0, 0);   // byte write even, R12
      acc(0, 2'b01, 1, 2'b00, 1, 0, 0, 0);   // byte write odd
      acc(1, 2'b01, 1, 2'b00, 0, 1, 0, 0);   // byte read odd
      acc(1, 2'b00, 0, 2'b00, 1, 0, 0, 0);   // R6 long read
      acc(0, 2'b00, 0, 2'b00, 0, 1, 0, 0);   // R6 long write
      acc(1, 2'b01, 1, 2'b11, 1, 0, 3'd5, 1); // R4 autovectored interrupt acknowledge
      acc(1, 2'b01, 1, 2'b11, 1, 0, 3'd2, 0); // R3 interrupt acknowledge, waits dtack
      acc(1, 2'b10, 0, 2'b10, 1, 1, 0, 0);   // R11 special type gives fc 000

      // R10: halt before the start holds the request pending
      cpu_halt = 1'b1;
      start_acc(1, 2'b10, 0, 2'b00, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
         chk(!leg_as, "R10 no start under halt", leg_as, 0);
         @(negedge clk);
      end
      cpu_halt = 1'b0;
      @(negedge clk);
      chk(leg_as, "R10 start after halt release", leg_as, 1);
      finish_acc();

      // R3/R9/R10: cycle held open, halt and ownership toggled in the wait
      hold_ack = 1'b1;
      start_acc(1, 2'b10, 0, 2'b00, 1, 0, 0, 0);
      repeat (5) @(negedge clk);
      chk(leg_as && !cpu_ta, "R3 wait holds cycle", {leg_as, cpu_ta}, 2);
      cpu_halt = 1'b1;
      @(negedge clk);
      chk({oe_rd16, oe_rd8, oe_wr16, oe_wr8} == 0, "R9 halt drops oe", oe_rd16, 0);
      chk(leg_as, "R10 halt lets cycle run", leg_as, 1);
      cpu_halt = 1'b0; cpu_own = 1'b0;
      @(negedge clk);
      chk({oe_rd16, oe_rd8, oe_wr16, oe_wr8} == 0, "R9 no ownership drops oe", oe_rd16, 0);
      cpu_own = 1'b1;
      @(negedge clk);
      chk(oe_rd16, "R9 oe returns", oe_rd16, 1);
      hold_ack = 1'b0;
      finish_acc();

      // random traffic
      for (int k = 0; k < 24; k++) begin
         logic [1:0] tt, siz;
         tt  = 2'($urandom_range(0, 3));
         siz = 2'($urandom_range(0, 2));
         acc(1'($urandom), siz, 1'($urandom), tt, 1'($urandom), 1'($urandom),
             LVL_W'($urandom), (tt == 2'b11) ? 1'($urandom) : 1'b0);
      end

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all transfers answered", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule